// File: doc/BRIEF.md
# Reset-Time Lookup Table Preloader

After reset is released, this block copies four small lookup tables (a tile colour lookup, an object colour lookup and the two halves of a palette) out of a shared external byte-wide ROM into four on-chip RAMs. Once the copy is done, the video path reads those tables from the RAMs and never has to compete for ROM bandwidth. The regions it reads sit inside the main processor's program window at 0x6000–0x7FFF, in a part of that window the processor never fetches from. For this reason the copy runs only while the processors are held in reset.

The block walks one ROM address through the regions in a fixed order. For each byte it raises a read request and holds the address until the ROM side acknowledges, and it takes the data in the same cycle as the acknowledge. In the next cycle it drives a one-cycle write strobe to the RAM that owns the byte, together with the byte's offset inside its table and the data. A busy output stays high for the whole copy, and the surrounding logic uses it to hold the processors in reset.

Top module: `lut_preload`

## Requirements
- R1: During reset and in the first cycle after reset is released, `busy` is 1, `rd_req` is 1, `rd_addr` is 0x6000 and no write strobe is active, so the copy starts with no outside trigger.
- R2: While `rd_req` is 1 and `rd_ack` is 0, `rd_req` stays 1 and `rd_addr` does not change. The byte on `rd_data` is taken in the cycle where `rd_req` and `rd_ack` are both 1.
- R3: Every address is read exactly once, in ascending order: tile lookup 0x6000–0x60FF (256 bytes), then object lookup 0x6100–0x61FF (256 bytes), then palette high 0x6200–0x621F (32 bytes), then palette low 0x6220–0x623F (32 bytes).
- R4: Each accepted read produces exactly one write strobe, one cycle wide, in the cycle after the acknowledge. Only one bit of `tbl_we` is ever set: bit 0 for tile lookup, bit 1 for object lookup, bit 2 for palette high, bit 3 for palette low.
- R5: With each strobe, `tbl_offs` equals the ROM address minus the base of its region (from 0 up to the table length minus 1), and `tbl_wdata` equals the byte that was acknowledged.
- R6: `rd_req` is 0 in every cycle in which a write strobe is active, so each byte takes at least two cycles.
- R7: `busy` falls in the cycle right after the strobe for the last palette-low byte and then stays 0 until the next reset.
- R8: Once `busy` is 0, `rd_ack` and `rd_data` have no effect: `rd_req` stays 0 and no strobe occurs.
- R9: Asserting reset partway through a copy abandons it. After release, the copy starts again from 0x6000 and rewrites all four tables completely.
- R10: The copy is correct for any acknowledge latency, including an acknowledge in the first cycle of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts a new copy |
| rd_req | output | 1 | ROM read request, held until acknowledged |
| rd_addr | output | 16 | ROM byte address of the current request |
| rd_ack | input | 1 | ROM acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | 8 | ROM read data |
| tbl_we | output | 4 | One-cycle write strobes, one per target RAM |
| tbl_offs | output | 8 | Byte offset within the target table |
| tbl_wdata | output | 8 | Byte to write |
| busy | output | 1 | High from reset until the last byte is written |

## Verification
The bench uses the default region bases and lengths. This means each of the 576 region bytes is walked for real: the 256-byte tables reach the largest offset an 8-bit offset can hold, and the two 32-byte palette halves sit next to each other inside one 64-byte span, so a wrong boundary between them shows up at once. The bench's ROM model gives each byte a value that depends on its address and acknowledges after 0, 1, 2 or 5 wait cycles. This covers the same-cycle acknowledge and long holds of the request. A reset partway through a copy and a burst of acknowledges after the copy has finished are also applied.

// File: rtl/lut_preload_pkg.sv
package lut_preload_pkg;

    localparam int LP_ADDR_W = 16;
    localparam int LP_DATA_W = 8;
    localparam int LP_OFFS_W = 8;
    localparam int LP_N_TBL  = 4;

    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_WRITE = 2'd1,
        ST_IDLE  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [LP_OFFS_W-1:0] offs;
        logic [LP_DATA_W-1:0] data;
    } wr_beat_t;

    function automatic logic [LP_N_TBL-1:0] sel_onehot(input logic [$clog2(LP_N_TBL)-1:0] idx);
        logic [LP_N_TBL-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/lpl_cursor.sv
module lpl_cursor
    import lut_preload_pkg::*;
#(
    parameter int ADDR_W = LP_ADDR_W,
    parameter int OFFS_W = LP_OFFS_W,
    parameter int N_TBL  = LP_N_TBL,
    parameter logic [N_TBL*ADDR_W-1:0]     BASES = '0,
    parameter logic [N_TBL*(OFFS_W+1)-1:0] LENS  = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    output logic [$clog2(N_TBL)-1:0] idx,
    output logic [OFFS_W-1:0]        offs,
    output logic [ADDR_W-1:0]        addr,
    output logic                     last_all
);
    localparam int IDX_W = $clog2(N_TBL);
    localparam int LEN_W = OFFS_W + 1;

    logic [ADDR_W-1:0] base_a [N_TBL];
    logic [LEN_W-1:0]  len_a  [N_TBL];

    for (genvar i = 0; i < N_TBL; i++) begin : g_region
        assign base_a[i] = BASES[i*ADDR_W +: ADDR_W];
        assign len_a[i]  = LENS[i*LEN_W +: LEN_W];
    end

    logic last_byte;
    assign last_byte = ({1'b0, offs} == (len_a[idx] - LEN_W'(1)));
    assign last_all  = last_byte && (idx == IDX_W'(N_TBL - 1));
    assign addr      = base_a[idx] + ADDR_W'(offs);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            offs <= '0;
        end else if (step) begin
            if (last_byte) begin
                idx  <= idx + IDX_W'(1);
                offs <= '0;
            end else begin
                offs <= offs + OFFS_W'(1);
            end
        end
    end

    AST_OFFS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        {1'b0, offs} < len_a[idx]) else $error("offset beyond table length"); // R5

    AST_STEP_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (step && !last_byte) |=> (addr == $past(addr) + ADDR_W'(1))) else $error("address not ascending"); // R3

endmodule

// File: rtl/lpl_seq.sv
module lpl_seq
    import lut_preload_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack,
    input  logic last_all,
    output logic req,
    output logic step,
    output logic busy
);
    seq_state_e state;
    logic       fin;

    assign req  = (state == ST_READ);
    assign step = req && ack;
    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_READ;
            fin   <= 1'b0;
        end else begin
            unique case (state)
                ST_READ: begin
                    if (ack) begin
                        state <= ST_WRITE;
                        fin   <= last_all;
                    end
                end
                ST_WRITE: state <= fin ? ST_IDLE : ST_READ;
                ST_IDLE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> (state == ST_IDLE)) else $error("left idle without reset"); // R7

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |=> (state != ST_WRITE)) else $error("write state held"); // R6

endmodule

// File: rtl/lpl_wrport.sv
module lpl_wrport
    import lut_preload_pkg::*;
#(
    parameter int N_TBL = LP_N_TBL
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go,
    input  logic [$clog2(N_TBL)-1:0] idx,
    input  wr_beat_t                 beat_in,
    output logic [N_TBL-1:0]         we,
    output wr_beat_t                 beat_q
);
    localparam int IDX_W = $clog2(N_TBL);

    for (genvar i = 0; i < N_TBL; i++) begin : g_we
        always_ff @(posedge clk) begin
            if (rst) we[i] <= 1'b0;
            else     we[i] <= go && (idx == IDX_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     beat_q <= '0;
        else if (go) beat_q <= beat_in;
    end

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we)) else $error("more than one strobe"); // R4

    AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|we) |=> !(|we)) else $error("strobe wider than one cycle"); // R4

    AST_WE_FOLLOWS_GO: assert property (@(posedge clk) disable iff (rst)
        go |=> ($countones(we) == 1)) else $error("accepted byte not written"); // R4

endmodule

// File: rtl/lut_preload.sv
module lut_preload
    import lut_preload_pkg::*;
#(
    parameter int ADDR_W = LP_ADDR_W,
    parameter int DATA_W = LP_DATA_W,
    parameter int OFFS_W = LP_OFFS_W,
    parameter int N_TBL  = LP_N_TBL,
    parameter logic [N_TBL*ADDR_W-1:0] BASES =
        {16'h6220, 16'h6200, 16'h6100, 16'h6000},
    parameter logic [N_TBL*(OFFS_W+1)-1:0] LENS =
        {9'd32, 9'd32, 9'd256, 9'd256}
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic [N_TBL-1:0]  tbl_we,
    output logic [OFFS_W-1:0] tbl_offs,
    output logic [DATA_W-1:0] tbl_wdata,
    output logic              busy
);
    localparam int IDX_W = $clog2(N_TBL);

    logic             step;
    logic             last_all;
    logic [IDX_W-1:0] idx;
    logic [OFFS_W-1:0] offs;
    wr_beat_t         beat_in;
    wr_beat_t         beat_q;

    lpl_cursor #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .N_TBL(N_TBL),
        .BASES(BASES), .LENS(LENS)
    ) u_cursor (
        .clk(clk), .rst(rst), .step(step),
        .idx(idx), .offs(offs), .addr(rd_addr), .last_all(last_all)
    );

    lpl_seq u_seq (
        .clk(clk), .rst(rst), .ack(rd_ack), .last_all(last_all),
        .req(rd_req), .step(step), .busy(busy)
    );

    assign beat_in.offs = offs;
    assign beat_in.data = rd_data;

    lpl_wrport #(.N_TBL(N_TBL)) u_wr (
        .clk(clk), .rst(rst), .go(step), .idx(idx),
        .beat_in(beat_in), .we(tbl_we), .beat_q(beat_q)
    );

    assign tbl_offs  = beat_q.offs;
    assign tbl_wdata = beat_q.data;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))) else $error("request dropped or address moved"); // R2

    AST_DATA_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack) |=> (tbl_wdata == $past(rd_data))) else $error("wrong byte written"); // R5

    AST_NO_REQ_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|tbl_we) |-> !rd_req) else $error("request during write"); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_req && (tbl_we == '0))) else $error("activity after copy"); // R8

    AST_BUSY_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy) else $error("busy rose without reset"); // R7

endmodule

// File: tb/lut_preload_tb.sv
module lut_preload_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic [3:0]  tbl_we;
    logic [7:0]  tbl_offs;
    logic [7:0]  tbl_wdata;
    logic        busy;

    always #2 clk = ~clk;

    lut_preload u_dut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .tbl_we(tbl_we),
        .tbl_offs(tbl_offs), .tbl_wdata(tbl_wdata), .busy(busy)
    );

    localparam int TOTAL = 576;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // stimulus row: {latency[3:0], table[1:0], offset[7:0], expected source address[15:0]}
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {4'd0, 2'd0, 8'h00, 16'h6000},
        {4'd0, 2'd0, 8'hFF, 16'h60FF},
        {4'd0, 2'd1, 8'h00, 16'h6100},
        {4'd0, 2'd3, 8'h1F, 16'h623F},
        {4'd2, 2'd1, 8'hFF, 16'h61FF},
        {4'd2, 2'd2, 8'h00, 16'h6200},
        {4'd2, 2'd2, 8'h1F, 16'h621F},
        {4'd2, 2'd3, 8'h00, 16'h6220},
        {4'd5, 2'd0, 8'h80, 16'h6080},
        {4'd5, 2'd3, 8'h10, 16'h6230}
    };

    // bench ROM model and scoreboard state
    bit   rom_en = 0;
    bit   junk = 0;
    int   lat = 0;
    int   wt = 0;
    int   exp_i = 0;
    bit   pend = 0;
    logic [3:0] exp_we;
    logic [7:0] exp_off;
    logic [7:0] exp_dat;
    int   cyc = 0;
    int   last_wr_cyc = -1;
    int   fall_cyc = -1;
    int   cnt [4];
    logic [7:0] mem [4][256];

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], 1'b0} ^ 8'hA5;
    endfunction

    function automatic int tgt_of(input int i);
        if (i < 256) return 0;
        if (i < 512) return 1;
        if (i < 544) return 2;
        return 3;
    endfunction

    function automatic int offs_of(input int i);
        if (i < 256) return i;
        if (i < 512) return i - 256;
        if (i < 544) return i - 512;
        return i - 544;
    endfunction

    function automatic logic [15:0] addr_of(input int i);
        if (i < 256) return 16'h6000 + 16'(i);
        if (i < 512) return 16'h6100 + 16'(i - 256);
        if (i < 544) return 16'h6200 + 16'(i - 512);
        return 16'h6220 + 16'(i - 544);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
        end
    endtask

    // ROM model and output monitor, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rom_en || junk) begin
                if (pend) begin
                    chk(tbl_we == exp_we, "R4", int'(tbl_we), int'(exp_we));
                    chk(tbl_offs == exp_off, "R5", int'(tbl_offs), int'(exp_off));
                    chk(tbl_wdata == exp_dat, "R5", int'(tbl_wdata), int'(exp_dat));
                    chk(!rd_req, "R6", int'(rd_req), 0);
                    last_wr_cyc = cyc;
                    pend = 0;
                end else begin
                    chk(tbl_we == 4'b0000, "R4", int'(tbl_we), 0);
                end
                for (int t = 0; t < 4; t++) begin
                    if (tbl_we[t]) begin
                        mem[t][tbl_offs] = tbl_wdata;
                        cnt[t]++;
                    end
                end
                if (!busy && fall_cyc < 0) fall_cyc = cyc;
            end
            if (junk) begin
                rd_ack  = 1'b1;
                rd_data = 8'hFF;
                chk(!rd_req, "R8", int'(rd_req), 0);
                chk(!busy, "R8", int'(busy), 0);
            end else if (rom_en && rd_req) begin
                chk(rd_addr == addr_of(exp_i), "R3", int'(rd_addr), int'(addr_of(exp_i)));
                if (wt >= lat) begin
                    rd_ack  = 1'b1;
                    rd_data = rom_byte(rd_addr);
                    exp_we  = 4'(1 << tgt_of(exp_i));
                    exp_off = 8'(offs_of(exp_i));
                    exp_dat = rom_byte(rd_addr);
                    pend    = 1;
                    exp_i++;
                    wt      = 0;
                end else begin
                    rd_ack = 1'b0;
                    wt++;
                end
            end else begin
                rd_ack = 1'b0;
            end
        end
    end

    task automatic do_reset(input int l);
        @(posedge clk); #1;
        rst = 1'b1;
        rom_en = 0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
        end
        // R1 / R9: reset state
        chk(busy == 1'b1, "R1", int'(busy), 1);
        chk(rd_req == 1'b1, "R1", int'(rd_req), 1);
        chk(rd_addr == 16'h6000, "R1", int'(rd_addr), 16'h6000);
        chk(tbl_we == 4'b0000, "R1", int'(tbl_we), 0);
        lat = l; wt = 0; exp_i = 0; pend = 0;
        last_wr_cyc = -1; fall_cyc = -1;
        for (int t = 0; t < 4; t++) begin
            cnt[t] = 0;
            for (int o = 0; o < 256; o++) mem[t][o] = 8'hEE;
        end
        rst = 1'b0;
        rom_en = 1;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000 && fall_cyc < 0; k++) @(posedge clk);
        #1;
        chk(fall_cyc >= 0, "R7", fall_cyc, 1);
        chk(exp_i == TOTAL, "R3", exp_i, TOTAL);
        chk(fall_cyc == last_wr_cyc + 1, "R7", fall_cyc, last_wr_cyc + 1);
        chk(cnt[0] == 256, "R3", cnt[0], 256);
        chk(cnt[1] == 256, "R3", cnt[1], 256);
        chk(cnt[2] == 32, "R3", cnt[2], 32);
        chk(cnt[3] == 32, "R3", cnt[3], 32);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cur_lat;
        cur_lat = -1;
        // table-driven runs, latency taken from each row (R10)
        for (int v = 0; v < NV; v++) begin
            int l, t, o;
            logic [15:0] a;
            l = int'(VEC[v][29:26]);
            t = int'(VEC[v][25:24]);
            o = int'(VEC[v][23:16]);
            a = VEC[v][15:0];
            if (l != cur_lat) begin
                do_reset(l);
                wait_done();
                cur_lat = l;
            end
            chk(mem[t][o] == rom_byte(a), "R10", int'(mem[t][o]), int'(rom_byte(a)));
        end

        // R8: acknowledges after completion are ignored
        rom_en = 0;
        junk = 1;
        repeat (20) @(posedge clk);
        #1;
        junk = 0;
        chk(busy == 1'b0, "R8", int'(busy), 0);
        @(negedge clk);
        rd_ack = 1'b0;

        // R9: reset partway through a copy restarts from the first table
        do_reset(1);
        repeat (300) @(posedge clk);
        chk(busy == 1'b1, "R9", int'(busy), 1);
        do_reset(1);
        wait_done();
        chk(mem[0][0] == rom_byte(16'h6000), "R9", int'(mem[0][0]), int'(rom_byte(16'h6000)));
        chk(mem[1][8'h7F] == rom_byte(16'h617F), "R9", int'(mem[1][8'h7F]), int'(rom_byte(16'h617F)));
        chk(mem[3][8'h1F] == rom_byte(16'h623F), "R9", int'(mem[3][8'h1F]), int'(rom_byte(16'h623F)));

        // R2: long hold with busy still high and address steady is covered by R3 checks at latency 5
        do_reset(5);
        repeat (3) @(posedge clk);
        #1;
        chk(rd_req == 1'b1, "R2", int'(rd_req), 1);
        chk(rd_addr == 16'h6000, "R2", int'(rd_addr), 16'h6000);
        wait_done();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule